// File: doc/BRIEF.md
# Thread Context Run-State Controller

This block keeps the run state of a fixed number of hardware thread contexts that share one core. Each context sits in one of four states: free (no thread assigned), running, parked (waiting, for example on a synchronization event) or stopped for good. Separate command lines for each context ask for it to be started, parked, released or stopped. A start request carries its own delay in cycles, so a thread can be scheduled to begin some cycles after the request.

The block drives a run enable for each context, which the execution pipeline uses to decide whether that context may issue. It also drives a single flag that rises once every context is stopped. A simulation harness or power controller can use that flag to end the run. Choosing among running contexts is left to the pipeline.

Top module: `thread_status_ctrl`

## Requirements
- R1: After reset every context reports the free state, every run enable is low and `all_halted` is low.
- R2: `ctx_state` carries the state of context i in bits [2i+1:2i], encoded free=00, running=01, parked=10, stopped=11.
- R3: The run enable of a context is high in exactly those cycles in which its state reads running (01).
- R4: A start request with delay D, sampled at a clock edge while the context is free or parked, makes the state read running from D cycles after that edge onward. A delay of 0 counts as 1. The state does not change while the delay runs. A start request given while the context is already running has no effect.
- R5: A park request moves the context to parked (10) at the next edge from any state except stopped, and it cancels a pending start.
- R6: A release request moves the context to free (00) at the next edge from any state except stopped, and it cancels a pending start.
- R7: A stop request moves the context to stopped (11) at the next edge and cancels a pending start. Once stopped, a context ignores every command until reset.
- R8: When several requests reach one context in the same cycle, stop wins over release, release wins over park, and park wins over start.
- R9: A new start request that arrives while a delayed start is still pending restarts the wait with the new delay.
- R10: `all_halted` is high exactly when every context reads stopped. It rises in the cycle after the last context is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_activate | input | NUM_CTX | Start request, one bit per context |
| act_delay | input | NUM_CTX*DLY_W | Start delay in cycles; context i uses bits [DLY_W*i +: DLY_W] |
| cmd_suspend | input | NUM_CTX | Park request, one bit per context |
| cmd_release | input | NUM_CTX | Release request, one bit per context |
| cmd_halt | input | NUM_CTX | Stop request, one bit per context |
| ctx_state | output | 2*NUM_CTX | Current state of every context |
| run_en | output | NUM_CTX | Per-context execution enable |
| all_halted | output | 1 | High when every context is stopped |

## Verification
Random traffic sets each request line sparsely, using delays from 0 to 6. This produces start requests that overlap pending waits, which separates a restart of the wait from a wait that keeps its old count. It also produces same-cycle conflicts, which expose a wrong priority order. Directed sequences cover a long single delay, a restart to a shorter delay, a delay of 0, and all four requests in one cycle. A final sweep stops the contexts one at a time, so the global flag must stay low until the last one is stopped, and later requests must not revive any context.

// File: rtl/thread_ctx_pkg.sv
package thread_ctx_pkg;

  typedef enum logic [1:0] {
    CTX_FREE    = 2'b00,
    CTX_RUN     = 2'b01,
    CTX_PARKED  = 2'b10,
    CTX_STOPPED = 2'b11
  } ctx_state_e;

  typedef enum logic [2:0] {
    REQ_NONE,
    REQ_START,
    REQ_PARK,
    REQ_RELEASE,
    REQ_STOP
  } ctx_req_e;

endpackage

// File: rtl/ctx_req_arb.sv
module ctx_req_arb
  import thread_ctx_pkg::*;
(
  input  logic     start_i,
  input  logic     park_i,
  input  logic     release_i,
  input  logic     stop_i,
  output ctx_req_e req_o
);

  // Fixed priority: stop > release > park > start
  always_comb begin
    if (stop_i)         req_o = REQ_STOP;
    else if (release_i) req_o = REQ_RELEASE;
    else if (park_i)    req_o = REQ_PARK;
    else if (start_i)   req_o = REQ_START;
    else                req_o = REQ_NONE;
  end

endmodule

// File: rtl/ctx_start_timer.sv
module ctx_start_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             fire_o,
  output logic             pending_o
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic             pend_q, pend_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign fire_o    = pend_q && (cnt_q == ONE);
  assign pending_o = pend_q;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear_i) begin
      pend_d = 1'b0;
    end else if (start_i) begin
      pend_d = 1'b1;
      cnt_d  = delay_i - ONE;
      cnt_en = 1'b1;
    end else if (pend_q) begin
      if (cnt_q == ONE) begin
        pend_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - ONE;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ctx_slot.sv
module ctx_slot
  import thread_ctx_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctx_req_e         req_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic [1:0]       state_o,
  output logic             run_o
);

  ctx_state_e state_q, state_d;
  logic       short_dly;
  logic       tmr_start, tmr_clear, tmr_fire, tmr_pend;

  assign short_dly = (delay_i <= DLY_W'(1));

  always_comb begin
    tmr_start = 1'b0;
    tmr_clear = 1'b0;
    if (state_q != CTX_STOPPED) begin
      unique case (req_i)
        REQ_STOP, REQ_RELEASE, REQ_PARK: tmr_clear = 1'b1;
        REQ_START: begin
          if (state_q != CTX_RUN) begin
            tmr_start = !short_dly;
            tmr_clear = short_dly;
          end
        end
        default: ;
      endcase
    end
  end

  ctx_start_timer #(.DLY_W(DLY_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (tmr_start),
    .clear_i   (tmr_clear),
    .delay_i   (delay_i),
    .fire_o    (tmr_fire),
    .pending_o (tmr_pend)
  );

  always_comb begin
    state_d = state_q;
    if (state_q != CTX_STOPPED) begin
      unique case (req_i)
        REQ_STOP:    state_d = CTX_STOPPED;
        REQ_RELEASE: state_d = CTX_FREE;
        REQ_PARK:    state_d = CTX_PARKED;
        REQ_START:   if (state_q != CTX_RUN && short_dly) state_d = CTX_RUN;
        default:     if (tmr_fire && tmr_pend) state_d = CTX_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CTX_FREE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign run_o   = (state_q == CTX_RUN);

endmodule

// File: rtl/thread_status_ctrl.sv
module thread_status_ctrl
  import thread_ctx_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int DLY_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CTX-1:0]       cmd_activate,
  input  logic [NUM_CTX*DLY_W-1:0] act_delay,
  input  logic [NUM_CTX-1:0]       cmd_suspend,
  input  logic [NUM_CTX-1:0]       cmd_release,
  input  logic [NUM_CTX-1:0]       cmd_halt,
  output logic [2*NUM_CTX-1:0]     ctx_state,
  output logic [NUM_CTX-1:0]       run_en,
  output logic                     all_halted
);

  logic [NUM_CTX-1:0] is_stopped;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    ctx_req_e req;

    ctx_req_arb u_arb (
      .start_i   (cmd_activate[g]),
      .park_i    (cmd_suspend[g]),
      .release_i (cmd_release[g]),
      .stop_i    (cmd_halt[g]),
      .req_o     (req)
    );

    ctx_slot #(.DLY_W(DLY_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .delay_i (act_delay[g*DLY_W +: DLY_W]),
      .state_o (ctx_state[2*g +: 2]),
      .run_o   (run_en[g])
    );

    assign is_stopped[g] = (ctx_state[2*g +: 2] == CTX_STOPPED);
  end

  assign all_halted = &is_stopped;

endmodule

// File: rtl/thread_status_ctrl_chk.sv
module thread_status_ctrl_chk #(
  parameter int NUM_CTX = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CTX-1:0]   cmd_activate,
  input logic [NUM_CTX-1:0]   cmd_suspend,
  input logic [NUM_CTX-1:0]   cmd_release,
  input logic [NUM_CTX-1:0]   cmd_halt,
  input logic [2*NUM_CTX-1:0] ctx_state,
  input logic [NUM_CTX-1:0]   run_en,
  input logic                 all_halted
);

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_chk
    assert_stop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_state[2*g +: 2] == 2'b11 |=> ctx_state[2*g +: 2] == 2'b11);

    assert_stop_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_halt[g] |=> ctx_state[2*g +: 2] == 2'b11);

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_release[g] && !cmd_halt[g] && ctx_state[2*g +: 2] != 2'b11)
      |=> ctx_state[2*g +: 2] == 2'b00);

    assert_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_suspend[g] && !cmd_release[g] && !cmd_halt[g] && ctx_state[2*g +: 2] != 2'b11)
      |=> ctx_state[2*g +: 2] == 2'b10);

    assert_run_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_en[g] |-> ctx_state[2*g +: 2] == 2'b01);
  end

  assert_flag_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    all_halted |-> run_en == '0);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    all_halted |=> all_halted);

endmodule

bind thread_status_ctrl thread_status_ctrl_chk #(.NUM_CTX(NUM_CTX)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_activate (cmd_activate),
  .cmd_suspend  (cmd_suspend),
  .cmd_release  (cmd_release),
  .cmd_halt     (cmd_halt),
  .ctx_state    (ctx_state),
  .run_en       (run_en),
  .all_halted   (all_halted)
);

// File: tb/thread_status_ctrl_test.sv
module thread_status_ctrl_test;

  localparam int N  = 4;
  localparam int DW = 8;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    cmd_activate;
  logic [N*DW-1:0] act_delay;
  logic [N-1:0]    cmd_suspend;
  logic [N-1:0]    cmd_release;
  logic [N-1:0]    cmd_halt;
  logic [2*N-1:0]  ctx_state;
  logic [N-1:0]    run_en;
  logic            all_halted;

  thread_status_ctrl #(.NUM_CTX(N), .DLY_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_activate(cmd_activate), .act_delay(act_delay),
    .cmd_suspend(cmd_suspend), .cmd_release(cmd_release), .cmd_halt(cmd_halt),
    .ctx_state(ctx_state), .run_en(run_en), .all_halted(all_halted)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;

  logic [1:0] m_state [N];
  bit         m_pend  [N];
  int         m_cnt   [N];
  string      m_tag   [N];

  // Reference model, advanced on each rising edge from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_state[i] = 2'b00; m_pend[i] = 0; m_cnt[i] = 0; m_tag[i] = "R1";
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        int d;
        int nreq;
        d = int'(act_delay[i*DW +: DW]);
        if (d < 1) d = 1;
        nreq = int'(cmd_activate[i]) + int'(cmd_suspend[i]) + int'(cmd_release[i]) + int'(cmd_halt[i]);
        if (m_state[i] == 2'b11) begin
          if (nreq != 0) m_tag[i] = "R7";
        end else if (cmd_halt[i]) begin
          m_state[i] = 2'b11; m_pend[i] = 0; m_tag[i] = (nreq > 1) ? "R8" : "R7";
        end else if (cmd_release[i]) begin
          m_state[i] = 2'b00; m_pend[i] = 0; m_tag[i] = (nreq > 1) ? "R8" : "R6";
        end else if (cmd_suspend[i]) begin
          m_state[i] = 2'b10; m_pend[i] = 0; m_tag[i] = (nreq > 1) ? "R8" : "R5";
        end else if (cmd_activate[i]) begin
          if (m_state[i] != 2'b01) begin
            m_tag[i] = m_pend[i] ? "R9" : "R4";
            if (d == 1) begin
              m_state[i] = 2'b01; m_pend[i] = 0;
            end else begin
              m_pend[i] = 1; m_cnt[i] = d - 1;
            end
          end else begin
            m_tag[i] = "R4";
          end
        end else if (m_pend[i]) begin
          if (m_cnt[i] == 1) begin
            m_state[i] = 2'b01; m_pend[i] = 0;
          end else begin
            m_cnt[i] = m_cnt[i] - 1;
          end
        end
      end
    end
  end

  function automatic logic exp_all_halted();
    for (int i = 0; i < N; i++) if (m_state[i] != 2'b11) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_outputs();
    for (int i = 0; i < N; i++) begin
      n_checks++;
      if (ctx_state[2*i +: 2] !== m_state[i]) begin
        n_fail++;
        $display("FAIL %s (R2 encoding) ctx %0d state: actual %b expected %b",
                 m_tag[i], i, ctx_state[2*i +: 2], m_state[i]);
      end
      n_checks++;
      if (run_en[i] !== (m_state[i] == 2'b01)) begin
        n_fail++;
        $display("FAIL R3 ctx %0d run_en: actual %b expected %b", i, run_en[i], m_state[i] == 2'b01);
      end
    end
    n_checks++;
    if (all_halted !== exp_all_halted()) begin
      n_fail++;
      $display("FAIL R10 all_halted: actual %b expected %b", all_halted, exp_all_halted());
    end
  endtask

  task automatic idle_inputs();
    cmd_activate = '0; cmd_suspend = '0; cmd_release = '0; cmd_halt = '0; act_delay = '0;
  endtask

  // Compare at the falling edge, then drive the next inputs
  task automatic step(input logic [N-1:0] a, input logic [N*DW-1:0] dl,
                      input logic [N-1:0] s, input logic [N-1:0] r, input logic [N-1:0] h);
    @(negedge clk);
    check_outputs();
    cmd_activate = a; act_delay = dl; cmd_suspend = s; cmd_release = r; cmd_halt = h;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired (R1..)");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_outputs(); // R1 during reset
    rst_n = 1'b1;
    step('0, '0, '0, '0, '0); // R1 after release

    // R4: long delay on context 0
    step(4'b0001, {24'd0, 8'd5}, '0, '0, '0);
    repeat (6) step('0, '0, '0, '0, '0);
    // R9: restart from parked with shorter delay
    step('0, '0, 4'b0001, '0, '0);
    step(4'b0001, {24'd0, 8'd6}, '0, '0, '0);
    step('0, '0, '0, '0, '0);
    step(4'b0001, {24'd0, 8'd2}, '0, '0, '0);
    repeat (4) step('0, '0, '0, '0, '0);
    // R4: delay zero behaves as one, on context 1
    step(4'b0010, '0, '0, '0, '0);
    step('0, '0, '0, '0, '0);
    // R8: all requests on context 2 and release+park on context 1
    step(4'b0100, {8'd0, 8'd3, 8'd0, 8'd0}, 4'b0110, 4'b0110, 4'b0100);
    repeat (2) step('0, '0, '0, '0, '0);

    // Re-enter reset, then random traffic
    @(negedge clk); rst_n = 1'b0; idle_inputs();
    @(negedge clk); rst_n = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0]    a, s, r, h;
      logic [N*DW-1:0] dl;
      for (int i = 0; i < N; i++) begin
        a[i] = ($urandom_range(0, 3) == 0);
        s[i] = ($urandom_range(0, 9) == 0);
        r[i] = ($urandom_range(0, 19) == 0);
        h[i] = ($urandom_range(0, 999) == 0);
        dl[i*DW +: DW] = DW'($urandom_range(0, 6));
      end
      step(a, dl, s, r, h);
    end

    // R10: stop one by one, then try to revive (R7)
    for (int i = 0; i < N; i++) begin
      step('0, '0, '0, '0, N'(1) << i);
      step('0, '0, '0, '0, '0);
    end
    step('1, '0, '1, '1, '0);
    repeat (3) step('0, '0, '0, '0, '0);
    @(negedge clk);
    check_outputs();
    finish_run();
  end

endmodule